// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is the station-management end of a two-wire MDIO bus. A host presents one command: a frame flavour (Clause 22 or Clause 45), a two-bit operation code, a 5-bit port/PHY address, a 5-bit register or device address and a 16-bit data word. The controller then derives the management clock from the system clock and serialises a 64-bit frame onto a tri-state data line. It drives the line through the control fields and, on writes and address frames, through the data field. On reads it releases the line from turnaround onward and captures the slave's answer.

A Clause 45 register access takes two commands. The host first issues an address frame whose data field holds the 16-bit register address, then issues a read, a write or a post-increment read. The block treats each command as one self-contained frame, so both access styles share the same sequencer. A busy flag covers the whole transaction. A one-cycle done strobe marks its end, after the line has rested released for one full clock period.

Top module: `mdio_master`

## Requirements
- R1: Under reset and after it, busy, done, mdc and mdio_oe are 0 and rdata is 0. A reset in the middle of a frame abandons it at once.
- R2: While busy, every bit slot is HALF_DIV system clocks with mdc low followed by HALF_DIV system clocks with mdc high. A frame has 64 bit slots plus one idle slot, so it has 65 rising edges. While not busy, mdc is held low.
- R3: The first 32 bit slots carry ones, with mdio_oe high.
- R4: The next two bits are the start code, 01 when cmd_c45 is 0 and 00 when cmd_c45 is 1.
- R5: After the start code come cmd_op (2 bits), cmd_port (5 bits) and cmd_dev (5 bits), each most significant bit first.
- R6: On a non-read frame the turnaround bits are 1 then 0, followed by the 16 bits of cmd_wdata MSB first. The line is driven for all 64 slots.
- R7: A frame is a read when cmd_c45=0 and cmd_op=10, or when cmd_c45=1 and cmd_op is 11 or 10. On a read, mdio_oe is low from the first turnaround slot (slot 46) to the end.
- R8: On a read, mdio_i is sampled at the falling mdc edge of each of the 16 data slots, MSB first. The resulting word appears on rdata in the cycle done is high.
- R9: mdio_o and mdio_oe change only while mdc is low: on command acceptance or in the cycle after a falling mdc edge. They never change at a rising edge.
- R10: After the 64th slot, mdio_oe is low for one full mdc period. Done then pulses high for exactly one cycle, in the same cycle in which busy falls.
- R11: busy is high from the cycle after a command is accepted (cmd_valid high while idle) until done. A cmd_valid presented while busy neither changes the frame in progress nor starts another one.
- R12: Frames that are not reads leave rdata unchanged.
- R13: A Clause 45 address frame (cmd_op=00) drives cmd_wdata in its data field, as a write does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request, taken when idle |
| cmd_c45 | input | 1 | 1 selects Clause 45 framing, 0 selects Clause 22 |
| cmd_op | input | 2 | Operation code placed in the frame |
| cmd_port | input | 5 | PHY / port address |
| cmd_dev | input | 5 | Register address (Clause 22) or device address (Clause 45) |
| cmd_wdata | input | 16 | Write data or register address for address frames |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction strobe |
| rdata | output | 16 | Last word read from the bus |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line output value |
| mdio_oe | output | 1 | Data line output enable (0 = released) |
| mdio_i | input | 1 | Data line input value |

## Verification
The bench aims at read classification first. A design that treats the Clause 45 post-increment code 10 as a write, or the Clause 22 code 10 as anything but a read, would keep driving the line through the data field. A capture that samples at the rising edge, or one slot off, returns a shifted word. That fault is exposed by asymmetric patterns fed by a slave model that changes its bit just after each rising edge. Further tests check that the released idle slot precedes done, that a mid-frame command is ignored, that a write leaves the previous read word in place, and that the data line never changes while mdc is high.

// File: rtl/mdio_pkg.sv
// Package: shared frame constants, command type and frame helpers for the
// MDIO master. Assumes the standard 64-slot frame (32 preamble + 32 body).
package mdio_pkg;

    localparam int ADDR_W     = 5;
    localparam int DATA_W     = 16;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 2 + 2 + 2 * ADDR_W + 2 + DATA_W;
    localparam int TA_SLOT    = PRE_BITS + 4 + 2 * ADDR_W;
    localparam int DATA_SLOT  = TA_SLOT + 2;
    localparam int IDX_W      = $clog2(FRAME_BITS + 1);

    typedef enum logic [1:0] {
        SQ_IDLE  = 2'd0,
        SQ_SHIFT = 2'd1,
        SQ_REST  = 2'd2
    } seq_state_t;

    typedef struct packed {
        logic              c45;
        logic [1:0]        op;
        logic [ADDR_W-1:0] port;
        logic [ADDR_W-1:0] dev;
        logic [DATA_W-1:0] data;
    } mdio_cmd_t;

    // Decide whether a command releases the line for returned data
    function automatic logic cmd_is_read(input mdio_cmd_t c);
        if (c.c45) begin
            return c.op[1];
        end
        return (c.op == 2'b10);
    endfunction

    // Assemble the full serial frame, first slot in the MSB
    function automatic logic [FRAME_BITS-1:0] build_frame(input mdio_cmd_t c);
        logic [1:0] st;
        st = c.c45 ? 2'b00 : 2'b01;
        return {{PRE_BITS{1'b1}}, st, c.op, c.port, c.dev, 2'b10, c.data};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
// Module: management clock generator. Splits each bit slot into HALF_DIV
// system clocks low then HALF_DIV high, and flags the last cycle of a slot.
// Assumes run stays high for whole slots; when run is low mdc rests low.
module mdio_clkgen #(
    parameter int HALF_DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic mdc,
    output logic slot_end
);
    localparam int CNT_W = (2 * HALF_DIV > 1) ? $clog2(2 * HALF_DIV) : 1;
    localparam logic [CNT_W-1:0] LAST_C = CNT_W'(2 * HALF_DIV - 1);
    localparam logic [CNT_W-1:0] RISE_C = CNT_W'(HALF_DIV - 1);
    localparam logic [CNT_W-1:0] HALF_C = CNT_W'(HALF_DIV);

    logic [CNT_W-1:0] phase_q;
    logic             mdc_q;

    assign slot_end = run && (phase_q == LAST_C);
    assign mdc      = mdc_q;

    // Phase counter and clock level for the current slot
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
            mdc_q   <= 1'b0;
        end else begin
            phase_q <= (phase_q == LAST_C) ? '0 : phase_q + 1'b1;
            if (phase_q == RISE_C) begin
                mdc_q <= 1'b1;
            end else if (phase_q == LAST_C) begin
                mdc_q <= 1'b0;
            end
        end
    end

    // Checker: length of each high phase of mdc
    logic [CNT_W-1:0] hi_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n || !mdc_q) begin
            hi_len_q <= '0;
        end else begin
            hi_len_q <= hi_len_q + 1'b1;
        end
    end

    p_mdc_high_len_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdc_q) |-> (hi_len_q == HALF_C));

    p_mdc_rest_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !mdc_q);

endmodule

// File: rtl/mdio_frame_seq.sv
// Module: frame sequencer. Latches a command while idle, shifts the frame
// out one slot per slot_end, releases the line on reads, captures read data
// at falling mdc edges, rests one released slot, then strobes done.
// Assumes slot_end comes from the clock generator and coincides with the
// falling mdc edge.
module mdio_frame_seq
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  mdio_cmd_t         cmd,
    input  logic              slot_end,
    input  logic              mdio_i,
    output logic              run,
    output logic              busy,
    output logic              done,
    output logic              mdio_o,
    output logic              mdio_oe,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [IDX_W-1:0] LAST_IDX   = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] PRE_TA_IDX = IDX_W'(TA_SLOT - 1);
    localparam logic [IDX_W-1:0] TA_IDX     = IDX_W'(TA_SLOT);
    localparam logic [IDX_W-1:0] DAT_IDX    = IDX_W'(DATA_SLOT);

    seq_state_t            state_q;
    logic [IDX_W-1:0]      idx_q;
    logic [FRAME_BITS-1:0] shreg_q;
    logic                  rd_q;
    logic [DATA_W-1:0]     cap_q;
    logic [DATA_W-1:0]     rdata_q;
    logic                  done_q;
    logic                  o_q;
    logic                  oe_q;
    logic [FRAME_BITS-1:0] frame_w;

    assign frame_w = build_frame(cmd);
    assign busy    = (state_q != SQ_IDLE);
    assign run     = busy;
    assign done    = done_q;
    assign mdio_o  = o_q;
    assign mdio_oe = oe_q;
    assign rdata   = rdata_q;

    // Main sequencer: accept, shift, rest, finish
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            idx_q   <= '0;
            shreg_q <= '0;
            rd_q    <= 1'b0;
            cap_q   <= '0;
            rdata_q <= '0;
            done_q  <= 1'b0;
            o_q     <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (cmd_valid) begin
                        shreg_q <= frame_w << 1;
                        o_q     <= frame_w[FRAME_BITS-1];
                        oe_q    <= 1'b1;
                        rd_q    <= cmd_is_read(cmd);
                        idx_q   <= '0;
                        state_q <= SQ_SHIFT;
                    end
                end
                SQ_SHIFT: begin
                    if (slot_end) begin
                        if (rd_q && (idx_q >= DAT_IDX)) begin
                            cap_q <= {cap_q[DATA_W-2:0], mdio_i};
                        end
                        idx_q <= idx_q + 1'b1;
                        if (idx_q == LAST_IDX) begin
                            oe_q    <= 1'b0;
                            o_q     <= 1'b0;
                            state_q <= SQ_REST;
                        end else begin
                            o_q     <= shreg_q[FRAME_BITS-1];
                            shreg_q <= shreg_q << 1;
                            oe_q    <= !(rd_q && (idx_q >= PRE_TA_IDX));
                        end
                    end
                end
                SQ_REST: begin
                    if (slot_end) begin
                        state_q <= SQ_IDLE;
                        done_q  <= 1'b1;
                        if (rd_q) begin
                            rdata_q <= cap_q;
                        end
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    p_idle_released_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdio_oe);

    p_read_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SQ_SHIFT && rd_q && idx_q >= TA_IDX) |-> !mdio_oe);

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_ends_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && $past(busy)));

    p_cmd_locked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(rd_q));

    p_rdata_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(rdata_q));

endmodule

// File: rtl/mdio_master.sv
// Module: MDIO management master top. Packs host command fields, ties the
// clock generator to the frame sequencer and exposes the tri-state pins.
// Assumes an external pull-up on the data line and HALF_DIV chosen so that
// mdc stays at or below 2.5 MHz (10 at a 50 MHz system clock).
module mdio_master #(
    parameter int HALF_DIV = 10
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    input  logic        cmd_c45,
    input  logic [1:0]  cmd_op,
    input  logic [4:0]  cmd_port,
    input  logic [4:0]  cmd_dev,
    input  logic [15:0] cmd_wdata,
    output logic        busy,
    output logic        done,
    output logic [15:0] rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    import mdio_pkg::*;

    mdio_cmd_t cmd_w;
    logic      run_w;
    logic      slot_end_w;

    // Gather the host fields into one command word
    always_comb begin
        cmd_w.c45  = cmd_c45;
        cmd_w.op   = cmd_op;
        cmd_w.port = cmd_port;
        cmd_w.dev  = cmd_dev;
        cmd_w.data = cmd_wdata;
    end

    mdio_clkgen #(.HALF_DIV(HALF_DIV)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_w),
        .mdc      (mdc),
        .slot_end (slot_end_w)
    );

    mdio_frame_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd_w),
        .slot_end  (slot_end_w),
        .mdio_i    (mdio_i),
        .run       (run_w),
        .busy      (busy),
        .done      (done),
        .mdio_o    (mdio_o),
        .mdio_oe   (mdio_oe),
        .rdata     (rdata)
    );

    p_mdc_idle_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mdc);

    p_line_steady_at_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdc) |-> ($stable(mdio_o) && $stable(mdio_oe)));

endmodule

// File: tb/test_mdio_master.sv
// Bench: table-driven frames through a bus monitor and slave model, then
// directed reset and busy-ignore tests.
module test_mdio_master;
    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_c45 = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [4:0]  cmd_port = '0;
    logic [4:0]  cmd_dev = '0;
    logic [15:0] cmd_wdata = '0;
    logic        busy, done, mdc, mdio_o, mdio_oe;
    logic [15:0] rdata;
    logic        phy_in = 1'b1;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    mdio_master #(.HALF_DIV(HALF)) i_mdio_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_c45(cmd_c45),
        .cmd_op(cmd_op), .cmd_port(cmd_port), .cmd_dev(cmd_dev),
        .cmd_wdata(cmd_wdata), .busy(busy), .done(done), .rdata(rdata),
        .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(phy_in)
    );

    // Bus monitor and slave model, sampled at the falling system edge
    logic [15:0] phy_word = '0;
    logic [63:0] cap_o = '0, cap_oe = '0;
    logic        gap_oe = 1'b1;
    int          rises = 0, hi_len = 0;
    bit          hi_bad = 0, chg_bad = 0;
    logic        mdc_p = 0, busy_p = 0, o_p = 0, oe_p = 0;
    always @(negedge clk) begin
        if (busy && !busy_p) begin
            rises = 0; hi_bad = 0; chg_bad = 0; cap_o = '0; cap_oe = '0; gap_oe = 1'b1;
        end
        if (busy && mdc && ((mdio_o !== o_p) || (mdio_oe !== oe_p))) chg_bad = 1;
        if (mdc && !mdc_p) begin
            if (rises < 64) begin
                cap_o[63-rises]  = mdio_o;
                cap_oe[63-rises] = mdio_oe;
                phy_in = (rises >= 48) ? phy_word[63-rises] : 1'b1;
            end else begin
                if (rises == 64) gap_oe = mdio_oe;
                phy_in = 1'b1;
            end
            rises++;
        end
        if (mdc) hi_len++;
        else begin
            if (mdc_p && hi_len != HALF) hi_bad = 1;
            hi_len = 0;
        end
        mdc_p = mdc; busy_p = busy; o_p = mdio_o; oe_p = mdio_oe;
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit is_rd(input logic c45, input logic [1:0] op);
        return c45 ? op[1] : (op == 2'b10);
    endfunction

    logic [15:0] last_rd = '0;

    task automatic issue(input logic c45, input logic [1:0] op, input logic [4:0] port,
                         input logic [4:0] dev, input logic [15:0] wd);
        @(negedge clk);
        cmd_c45 = c45; cmd_op = op; cmd_port = port; cmd_dev = dev; cmd_wdata = wd;
        cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy === 1'b1, "R11 busy after accept", {63'd0, busy}, 64'd1);
    endtask

    task automatic wait_done();
        int cyc = 0;
        while (done !== 1'b1 && cyc < 5000) begin
            @(negedge clk);
            cyc++;
        end
        chk(done === 1'b1, "R10 done seen (watchdog)", {63'd0, done}, 64'd1);
        chk(busy === 1'b0, "R10 busy low with done", {63'd0, busy}, 64'd0);
    endtask

    task automatic check_frame(input logic c45, input logic [1:0] op, input logic [4:0] port,
                               input logic [4:0] dev, input logic [15:0] wd, input logic [15:0] phy);
        logic [63:0] exp_o, exp_oe;
        bit rd;
        rd     = is_rd(c45, op);
        exp_o  = {32'hFFFF_FFFF, (c45 ? 2'b00 : 2'b01), op, port, dev, 2'b10, wd};
        exp_oe = rd ? {{46{1'b1}}, 18'd0} : {64{1'b1}};
        chk(cap_o[63:32] == 32'hFFFF_FFFF, "R3 preamble", {32'd0, cap_o[63:32]}, 64'hFFFF_FFFF);
        chk(cap_o[31:30] == exp_o[31:30], "R4 start code", {62'd0, cap_o[31:30]}, {62'd0, exp_o[31:30]});
        chk(cap_o[29:18] == exp_o[29:18], "R5 op/port/dev", {52'd0, cap_o[29:18]}, {52'd0, exp_o[29:18]});
        chk(cap_oe == exp_oe, "R7 output enable pattern", cap_oe, exp_oe);
        if (!rd) begin
            if (c45 && op == 2'b00)
                chk(cap_o[17:0] == exp_o[17:0], "R13 address frame data", {46'd0, cap_o[17:0]}, {46'd0, exp_o[17:0]});
            else
                chk(cap_o[17:0] == exp_o[17:0], "R6 turnaround+data", {46'd0, cap_o[17:0]}, {46'd0, exp_o[17:0]});
            chk(rdata == last_rd, "R12 rdata kept", {48'd0, rdata}, {48'd0, last_rd});
        end else begin
            chk(rdata == phy, "R8 read data", {48'd0, rdata}, {48'd0, phy});
            last_rd = phy;
        end
        chk(rises == 65, "R2 mdc rising edges", rises, 65);
        chk(!hi_bad, "R2 mdc high phase length", {63'd0, hi_bad}, 64'd0);
        chk(gap_oe === 1'b0, "R10 released rest slot", {63'd0, gap_oe}, 64'd0);
        chk(!chg_bad, "R9 line steady while mdc high", {63'd0, chg_bad}, 64'd0);
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", {63'd0, done}, 64'd0);
    endtask

    // c45, op, port, dev, wdata, phy response
    localparam int NV = 7;
    localparam logic [44:0] VEC [NV] = '{
        {1'b0, 2'b01, 5'h01, 5'h00, 16'hA55A, 16'h0000},
        {1'b0, 2'b10, 5'h1F, 5'h1F, 16'h0000, 16'h1234},
        {1'b1, 2'b00, 5'h03, 5'h01, 16'h8001, 16'h0000},
        {1'b1, 2'b01, 5'h03, 5'h01, 16'hFFFF, 16'h0000},
        {1'b1, 2'b11, 5'h10, 5'h07, 16'h0000, 16'hC3A5},
        {1'b1, 2'b10, 5'h0A, 5'h15, 16'h0000, 16'h0001},
        {1'b0, 2'b01, 5'h00, 5'h10, 16'h0000, 16'hFFFF}
    };

    // Global watchdog
    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        cmd_valid = 1'b1;
        repeat (5) @(negedge clk);
        cmd_valid = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk({busy, done, mdc, mdio_oe} == 4'b0000, "R1 reset outputs", {60'd0, busy, done, mdc, mdio_oe}, 64'd0);
        chk(rdata == 16'h0, "R1 reset rdata", {48'd0, rdata}, 64'd0);

        for (int v = 0; v < NV; v++) begin
            phy_word = VEC[v][15:0];
            issue(VEC[v][44], VEC[v][43:42], VEC[v][41:37], VEC[v][36:32], VEC[v][31:16]);
            wait_done();
            check_frame(VEC[v][44], VEC[v][43:42], VEC[v][41:37], VEC[v][36:32], VEC[v][31:16], VEC[v][15:0]);
        end

        // R11: command presented mid-frame must be ignored
        phy_word = 16'h5AA5;
        issue(1'b0, 2'b10, 5'h02, 5'h03, 16'h0000);
        repeat (300) @(negedge clk);
        cmd_c45 = 1'b1; cmd_op = 2'b01; cmd_port = 5'h1F; cmd_dev = 5'h1F; cmd_wdata = 16'hDEAD;
        cmd_valid = 1'b1;
        repeat (3) @(negedge clk);
        cmd_valid = 1'b0;
        cmd_c45 = 1'b0; cmd_op = 2'b10; cmd_port = 5'h02; cmd_dev = 5'h03; cmd_wdata = 16'h0000;
        wait_done();
        check_frame(1'b0, 2'b10, 5'h02, 5'h03, 16'h0000, 16'h5AA5);
        repeat (100) @(negedge clk);
        chk(busy === 1'b0 && mdc === 1'b0, "R11 no late accept / R2 idle mdc",
            {62'd0, busy, mdc}, 64'd0);

        // R1: reset in the middle of a write frame
        issue(1'b0, 2'b01, 5'h04, 5'h05, 16'h1357);
        repeat (500) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk({busy, done, mdc, mdio_oe} == 4'b0000, "R1 mid-frame reset",
            {60'd0, busy, done, mdc, mdio_oe}, 64'd0);
        chk(rdata == 16'h0, "R1 rdata cleared", {48'd0, rdata}, 64'd0);
        rst_n = 1'b1;
        last_rd = 16'h0;
        phy_word = 16'h8000;
        issue(1'b0, 2'b10, 5'h06, 5'h07, 16'h0000);
        wait_done();
        check_frame(1'b0, 2'b10, 5'h06, 5'h07, 16'h0000, 16'h8000);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule